// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital timing controller for a successive-approximation converter. A start pulse launches one conversion. The conversion runs through four phases in a fixed order: synchronize, sample, convert and write result. The block divides the system clock by a selectable ratio to make the converter's basic clock. It uses that clock to time the sample and convert phases, and it gives the analog side a strobe or flag for each phase.

Two 2-bit fields set the timing. One picks the clock divider and the other picks how many basic-clock periods the sample phase lasts. Both fields are captured when a start is accepted, so software may rewrite them during a conversion without disturbing it. A start that arrives while a conversion is running is dropped. One conversion lasts four system clocks, plus the sample time, plus eight and a half basic-clock periods.

Top module: `adc_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `sample_en_o`, `conv_active_o`, `result_wr_o` and `adc_tick_o` are all 0.
- R2: `div_sel_i` sets the divider D: 0 gives 32, 1 gives 20, 2 gives 16 and 3 gives 12. The convert phase lasts 17*D/2 system clocks.
- R3: `smp_sel_i` sets the sample length S in basic-clock periods: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16. The sample phase lasts S*D system clocks.
- R4: `phase_o` reads 0 (synchronize), 1 (sample), 2 (convert) and 3 (write) while busy. Each conversion starts at 0, and the code only ever stays the same or steps up by one.
- R5: The synchronize phase lasts 3 system clocks. The write phase lasts 1 system clock, and `result_wr_o` is high only in that cycle.
- R6: `busy_o` goes high in the cycle after an accepted start. It stays high for exactly 4 + S*D + 17*D/2 cycles.
- R7: `div_sel_i` and `smp_sel_i` are sampled only in the cycle a start is accepted. Changing them during a conversion does not alter its timing.
- R8: A start pulse that arrives while `busy_o` is high, including during the write cycle, has no effect: no new conversion follows.
- R9: During the sample and convert phases, `adc_tick_o` pulses once every D system clocks, timed from the first sample cycle. This gives S pulses in sample and 8 in convert, and none in any other phase.
- R10: `done_o` is set in the cycle after the write phase and is cleared when the next start is accepted.
- R11: `sample_en_o` is high exactly when the phase is sample, and `conv_active_o` is high exactly when the phase is convert.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start request |
| div_sel_i | input | 2 | Basic-clock divider select |
| smp_sel_i | input | 2 | Sample length select |
| phase_o | output | 2 | Current phase code |
| sample_en_o | output | 1 | Sample-and-hold enable |
| conv_active_o | output | 1 | Conversion in progress |
| result_wr_o | output | 1 | Result write strobe |
| adc_tick_o | output | 1 | Basic-clock period pulse |
| busy_o | output | 1 | Conversion running |
| done_o | output | 1 | Last conversion finished |

## Verification
The bench sweeps all sixteen divider and sample settings. For each one it counts the cycles spent in every phase and the ticks inside each phase, and compares them with values worked out arithmetically. A design that rounded the half-period term would give a convert phase one half-period short or long for every divider. A design that restarted the divider late would shift the tick count in sample and convert. In each run the bench rewrites both fields to different values right after start. A design that does not shadow the fields would then show the wrong lengths. The bench also pulses start during convert and again during the single write cycle. A design that lets either pulse through would stay busy after the expected end.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int CW = 10,
  parameter int DW = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] div_sel_i,
  input  logic [1:0] smp_sel_i,
  output logic [1:0] phase_o,
  output logic       sample_en_o,
  output logic       conv_active_o,
  output logic       result_wr_o,
  output logic       adc_tick_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam logic [1:0] PH_SYNC = 2'd0;
  localparam logic [1:0] PH_SMP  = 2'd1;
  localparam logic [1:0] PH_CNV  = 2'd2;
  localparam logic [1:0] PH_WR   = 2'd3;
  localparam logic [CW-1:0] SYNC_LEN = CW'(3);

  logic          busy_q, done_q;
  logic [1:0]    ph_q;
  logic [CW-1:0] cnt_q, len;
  logic [DW-1:0] dv_q, dcnt_q, dv_new;
  logic [4:0]    sm_q, sm_new;
  logic          last, timing;

  always_comb begin
    case (div_sel_i)
      2'd0: dv_new = DW'(32);
      2'd1: dv_new = DW'(20);
      2'd2: dv_new = DW'(16);
      default: dv_new = DW'(12);
    endcase
    case (smp_sel_i)
      2'd0: sm_new = 5'd2;
      2'd1: sm_new = 5'd4;
      2'd2: sm_new = 5'd8;
      default: sm_new = 5'd16;
    endcase
  end

  always_comb begin
    case (ph_q)
      PH_SYNC: len = SYNC_LEN;
      PH_SMP:  len = CW'(sm_q) * CW'(dv_q);
      PH_CNV:  len = (CW'(17) * CW'(dv_q)) >> 1;
      default: len = CW'(1);
    endcase
  end

  assign last   = (cnt_q == len - CW'(1));
  assign timing = busy_q && (ph_q == PH_SMP || ph_q == PH_CNV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ph_q   <= PH_SYNC;
      cnt_q  <= '0;
      dv_q   <= DW'(32);
      sm_q   <= 5'd2;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        ph_q   <= PH_SYNC;
        cnt_q  <= '0;
        dv_q   <= dv_new;
        sm_q   <= sm_new;
      end
    end else if (last) begin
      cnt_q <= '0;
      if (ph_q == PH_WR) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        ph_q   <= PH_SYNC;
      end else begin
        ph_q <= ph_q + 2'd1;
      end
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dcnt_q <= '0;
    else if (!timing || dcnt_q == dv_q - DW'(1))
      dcnt_q <= '0;
    else
      dcnt_q <= dcnt_q + DW'(1);
  end

  assign phase_o       = ph_q;
  assign busy_o        = busy_q;
  assign done_o        = done_q;
  assign sample_en_o   = busy_q && ph_q == PH_SMP;
  assign conv_active_o = busy_q && ph_q == PH_CNV;
  assign result_wr_o   = busy_q && ph_q == PH_WR;
  assign adc_tick_o    = timing && dcnt_q == dv_q - DW'(1);
endmodule

module adc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [1:0] phase_o,
  input logic       sample_en_o,
  input logic       conv_active_o,
  input logic       result_wr_o,
  input logic       adc_tick_o,
  input logic       busy_o,
  input logic       done_o
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(sample_en_o || conv_active_o || result_wr_o || adc_tick_o));
  p_enter_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> phase_o == 2'd0);
  p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (phase_o == $past(phase_o) || phase_o == $past(phase_o) + 2'd1));
  p_write_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_wr_o |=> !busy_o && !result_wr_o);
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && phase_o != 2'd0) |=> !(busy_o && phase_o == 2'd0));
  p_tick_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adc_tick_o |-> (sample_en_o || conv_active_o));
  p_done_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    result_wr_o |=> done_o);
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_en_o, conv_active_o, result_wr_o}));
endmodule

bind adc_seq adc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_o(phase_o),
  .sample_en_o(sample_en_o), .conv_active_o(conv_active_o),
  .result_wr_o(result_wr_o), .adc_tick_o(adc_tick_o),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/adc_seq_tb.sv
module adc_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] div_sel_i = 2'd0, smp_sel_i = 2'd0;
  logic [1:0] phase_o;
  logic       sample_en_o, conv_active_o, result_wr_o, adc_tick_o, busy_o, done_o;
  int nchk = 0, nbad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_sel_i(div_sel_i),
    .smp_sel_i(smp_sel_i), .phase_o(phase_o), .sample_en_o(sample_en_o),
    .conv_active_o(conv_active_o), .result_wr_o(result_wr_o),
    .adc_tick_o(adc_tick_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dmap(input int s);
    case (s) 0: return 32; 1: return 20; 2: return 16; default: return 12; endcase
  endfunction
  function automatic int smap(input int s);
    return 2 << s;
  endfunction

  task automatic run(input int dsel, input int ssel);
    int d, s, n[4], tk[4], tot, bad_ord, bad_str, prev;
    d = dmap(dsel); s = smap(ssel);
    n = '{0, 0, 0, 0}; tk = '{0, 0, 0, 0}; tot = 0; bad_ord = 0; bad_str = 0; prev = 0;
    @(negedge clk);
    start_i = 1'b1; div_sel_i = 2'(dsel); smp_sel_i = 2'(ssel);
    @(negedge clk);
    start_i = 1'b0; div_sel_i = 2'(3 - dsel); smp_sel_i = 2'(3 - ssel);
    chk(busy_o === 1'b1, "R6 busy after start", int'(busy_o), 1);
    chk(done_o === 1'b0, "R10 done cleared", int'(done_o), 0);
    while (busy_o === 1'b1 && tot < 2000) begin
      if (tot == 0 && phase_o != 2'd0) bad_ord++;
      if (int'(phase_o) != prev && int'(phase_o) != prev + 1) bad_ord++;
      prev = int'(phase_o);
      n[phase_o]++;
      if (adc_tick_o) tk[phase_o]++;
      if (sample_en_o !== (phase_o == 2'd1) || conv_active_o !== (phase_o == 2'd2) ||
          result_wr_o !== (phase_o == 2'd3)) bad_str++;
      start_i = (phase_o == 2'd2 && n[2] == 3) || phase_o == 2'd3;
      tot++;
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(bad_ord == 0, "R4 phase order", bad_ord, 0);
    chk(n[0] == 3, "R5 sync length", n[0], 3);
    chk(n[3] == 1, "R5 write length", n[3], 1);
    chk(n[1] == s * d, "R3 R7 sample length", n[1], s * d);
    chk(n[2] == 17 * d / 2, "R2 R7 convert length", n[2], 17 * d / 2);
    chk(tot == 4 + s * d + 17 * d / 2, "R6 busy length", tot, 4 + s * d + 17 * d / 2);
    chk(tk[1] == s, "R9 sample ticks", tk[1], s);
    chk(tk[2] == 8, "R9 convert ticks", tk[2], 8);
    chk(tk[0] + tk[3] == 0, "R9 ticks outside", tk[0] + tk[3], 0);
    chk(bad_str == 0, "R11 strobes", bad_str, 0);
    chk(done_o === 1'b1, "R10 done set", int'(done_o), 1);
    for (int i = 0; i < 3; i++) begin
      chk(busy_o === 1'b0, "R8 start while busy ignored", int'(busy_o), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R1 reset busy/done", int'({busy_o, done_o}), 0);
    chk({sample_en_o, conv_active_o, result_wr_o, adc_tick_o} === 4'b0, "R1 reset strobes",
        int'({sample_en_o, conv_active_o, result_wr_o, adc_tick_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o === 1'b0, "R1 idle after reset", int'(busy_o), 0);
    for (int ds = 0; ds < 4; ds++)
      for (int ss = 0; ss < 4; ss++)
        run(ds, ss);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule